// File: doc/BRIEF.md
# Pattern-Based Fractional Clock Divider

This block derives a slower clock from a fast input clock by recirculating a preloaded bit pattern and presenting one bit of it per fast-clock cycle as the divided clock. The number of low-to-high transitions in one trip round the loop, set against the loop length, fixes the average division ratio. Non-integer ratios such as 2.5, 3.5 or 3.75 therefore come from the pattern contents and need no counter arithmetic. A fixed internal 25-step sequence covers the 6.25 ratio. A bypass path passes the fast clock straight through for divide-by-one.

Software programs the block through one 20-bit control word. The word is written in a fixed order: clear every field, set the loop length, raise the load strobe, place the pattern, drop the strobe, then open the output. An output gate holds the divided clock low while it is disabled. The gate opens or closes only while the pattern bit is low, so no shortened pulse appears.

Top module: `frac_pattern_div`

## Requirements
- R1: The control word decodes as follows. Bit 19 is output enable. Bit 18 is divide-by-one bypass. Bits 17:16 are the loop select. Bit 15 is the load strobe. Bits 14:0 are the pattern.
- R2: A synchronous active-high reset closes the output gate, clears the pattern ring and returns the fixed sequence to step 0. The output is low during reset. After reset is released, with the strobe low, the output stays low because the ring holds all zeros.
- R3: While the strobe is high, the ring is loaded from the pattern field on every cycle and does not rotate. Rotation resumes on the first cycle after the strobe falls. The output shows ring bit L-1. Each rotation moves bit i to bit i+1 and bit L-1 to bit 0, so a single one loaded at bit L-1 reappears at the output L cycles after the strobe falls.
- R4: Loop select 0 gives a 12-bit loop, 1 a 14-bit loop and 2 a 15-bit loop. Ring bits at or above the loop length are held and have no effect on the output.
- R5: With loop select 0, 1 or 2, any window of k·L cycles contains k times as many output rising edges as the pattern has cyclic runs of ones in its low L bits. The listed patterns are: 0x0aaa (÷2), 0x0db6 (÷3), 0x0ccc (÷4), 0x0e38 (÷6) and 0x0fc0 (÷12) at L=12; 0x36cc (÷3.5), 0x3c78 (÷7) and 0x3f80 (÷14) at L=14; 0x6666 (÷3.75), 0x739c (÷5), 0x78f0 (÷7.5), 0x7f80 (÷15) and 0x5294 (÷2.5) at L=15.
- R6: Loop select 3 plays a fixed 25-step sequence and ignores the pattern field. The sequence has four pulses, each high for 3 cycles, with periods of 7, 6, 6 and 6 cycles, giving ÷6.25. The strobe holds the sequence at step 0, and step 24 wraps to step 0.
- R7: With bypass set, the output equals the fast input clock while enabled and is low while disabled.
- R8: With enable low, the output is low once the current high phase has ended. The gate changes state only in cycles where the selected pattern bit is low, so a high phase is never cut short.
- R9: When enable rises in the middle of a stream, the first output pulse has its full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ctl_i | input | 20 | Control word: enable, bypass, loop select, load strobe, pattern |
| div_clk_o | output | 1 | Divided (or bypassed) clock |

## Verification
A corrupted ring shows at the output within one loop length, as a wrong count of rising edges in a window of whole loops. The edge count over twenty loops is therefore compared with the run count of each listed pattern. A wrong rotation direction or a missed strobe release moves the single-one marker off its exact cycle, which is checked cycle by cycle. A gate that switches while the pattern bit is high shows at once as a runt pulse or an extra high phase. These are checked by measuring the first pulse after enabling and the high samples that remain after disabling.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int PAT_W      = 15;
    localparam int FIX_LEN    = 25;
    localparam int FIX_PULSES = 4;
    localparam int CTL_W      = PAT_W + 5;
    localparam int LEN_W      = $clog2(PAT_W + 1);
    localparam int SEQ_W      = $clog2(FIX_LEN);

    typedef enum logic [1:0] {
        LOOP_12    = 2'd0,
        LOOP_14    = 2'd1,
        LOOP_15    = 2'd2,
        LOOP_FIXED = 2'd3
    } loop_sel_e;

    typedef struct packed {
        logic                 out_en;
        logic                 pass_thru;
        loop_sel_e            loop_sel;
        logic                 load;
        logic [PAT_W-1:0]     pattern;
    } div_ctl_t;

    function automatic logic [LEN_W-1:0] loop_len(input loop_sel_e sel);
        case (sel)
            LOOP_12: return LEN_W'(12);
            LOOP_14: return LEN_W'(14);
            default: return LEN_W'(PAT_W);
        endcase
    endfunction

    function automatic logic [PAT_W-1:0] rotate_ring(input logic [PAT_W-1:0] r,
                                                     input logic [LEN_W-1:0] len);
        logic [PAT_W-1:0] n;
        n    = r;
        n[0] = r[len - 1'b1];
        for (int i = 1; i < PAT_W; i++) begin
            if (i < int'(len)) n[i] = r[i-1];
        end
        return n;
    endfunction

    function automatic logic [FIX_LEN-1:0] fixed_seq_pattern();
        logic [FIX_LEN-1:0] v;
        int base;
        int extra;
        int p;
        int k;
        int plen;
        base  = FIX_LEN / FIX_PULSES;
        extra = FIX_LEN % FIX_PULSES;
        p     = 0;
        k     = 0;
        v     = '0;
        for (int i = 0; i < FIX_LEN; i++) begin
            plen = base + ((k < extra) ? 1 : 0);
            v[i] = (p < base / 2);
            p++;
            if (p == plen) begin
                p = 0;
                k++;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/fdiv_ring.sv
module fdiv_ring
    import fdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [PAT_W-1:0] pattern_i,
    input  loop_sel_e        sel_i,
    output logic [PAT_W-1:0] ring_q,
    output logic             msb_o
);

    logic [LEN_W-1:0] len;

    assign len   = loop_len(sel_i);
    assign msb_o = ring_q[len - 1'b1];

    always_ff @(posedge clk_i) begin
        if (rst_i)
            ring_q <= '0;
        else if (load_i)
            ring_q <= pattern_i;
        else
            ring_q <= rotate_ring(ring_q, len);
    end

endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq
    import fdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    output logic [SEQ_W-1:0] idx_q,
    output logic             bit_o
);

    localparam logic [FIX_LEN-1:0] SEQ_PAT = fixed_seq_pattern();
    localparam logic [SEQ_W-1:0]   LAST    = SEQ_W'(FIX_LEN - 1);

    assign bit_o = SEQ_PAT[idx_q];

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i)
            idx_q <= '0;
        else if (idx_q == LAST)
            idx_q <= '0;
        else
            idx_q <= idx_q + 1'b1;
    end

endmodule

// File: rtl/fdiv_gate.sv
module fdiv_gate (
    input  logic clk_i,
    input  logic rst_i,
    input  logic enable_i,
    input  logic pass_thru_i,
    input  logic pat_bit_i,
    output logic gate_q,
    output logic out_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            gate_q <= 1'b0;
        else if (pass_thru_i || !pat_bit_i)
            gate_q <= enable_i;
    end

    assign out_o = pass_thru_i ? (gate_q & clk_i) : (gate_q & pat_bit_i);

endmodule

// File: rtl/frac_pattern_div.sv
module frac_pattern_div
    import fdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CTL_W-1:0] ctl_i,
    output logic             div_clk_o
);

    div_ctl_t         ctl;
    logic [PAT_W-1:0] ring_q;
    logic             ring_bit;
    logic [SEQ_W-1:0] seq_idx;
    logic             seq_bit;
    logic             fixed_mode;
    logic             pat_bit;
    logic             gate_q;

    assign ctl        = div_ctl_t'(ctl_i);
    assign fixed_mode = (ctl.loop_sel == LOOP_FIXED);
    assign pat_bit    = fixed_mode ? seq_bit : ring_bit;

    fdiv_ring u_ring (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (ctl.load),
        .pattern_i (ctl.pattern),
        .sel_i     (ctl.loop_sel),
        .ring_q    (ring_q),
        .msb_o     (ring_bit)
    );

    fdiv_seq u_seq (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .run_i (fixed_mode && !ctl.load),
        .idx_q (seq_idx),
        .bit_o (seq_bit)
    );

    fdiv_gate u_gate (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .enable_i    (ctl.out_en),
        .pass_thru_i (ctl.pass_thru),
        .pat_bit_i   (pat_bit),
        .gate_q      (gate_q),
        .out_o       (div_clk_o)
    );

endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk
    import fdiv_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic [CTL_W-1:0] ctl_i,
    input logic             div_clk_o,
    input logic [PAT_W-1:0] ring_q,
    input logic             gate_q,
    input logic             pat_bit,
    input logic [SEQ_W-1:0] seq_idx
);

    AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        ctl_i[15] |=> ring_q == $past(ctl_i[PAT_W-1:0])); // R3

    AST_ROTATE_KEEPS_ONES: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctl_i[15] |=> $countones(ring_q) == $countones($past(ring_q))); // R4

    AST_GATE_SWITCH_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_q != $past(gate_q) && !$past(ctl_i[18])) |-> !$past(pat_bit)); // R8

    AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctl_i[19] && !pat_bit) |=> !div_clk_o); // R8

    AST_SEQ_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (seq_idx == SEQ_W'(FIX_LEN - 1) && ctl_i[17:16] == 2'd3 && !ctl_i[15])
            |=> seq_idx == '0); // R6

endmodule

bind frac_pattern_div fdiv_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ctl_i     (ctl_i),
    .div_clk_o (div_clk_o),
    .ring_q    (ring_q),
    .gate_q    (gate_q),
    .pat_bit   (pat_bit),
    .seq_idx   (seq_idx)
);

// File: tb/tb_frac_pattern_div.sv
module tb_frac_pattern_div;

    logic        clk;
    logic        rst;
    logic [19:0] ctl;
    logic        div_clk;
    int          n_chk;
    int          n_fail;
    bit          done;

    frac_pattern_div dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .ctl_i     (ctl),
        .div_clk_o (div_clk)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R1: field layout {enable[19], bypass[18], loop[17:16], strobe[15], pattern[14:0]}
    task automatic write_ctl(input bit en, input bit byp, input bit [1:0] sel,
                             input bit ld, input bit [14:0] pat);
        @(negedge clk);
        ctl = {en, byp, sel, ld, pat};
    endtask

    task automatic program_pattern(input bit [1:0] sel, input bit [14:0] pat, input bit en);
        write_ctl(0, 0, 2'd0, 0, 15'd0);
        write_ctl(0, 0, sel, 0, 15'd0);
        write_ctl(0, 0, sel, 1, 15'd0);
        write_ctl(0, 0, sel, 1, pat);
        write_ctl(0, 0, sel, 0, pat);
        write_ctl(en, 0, sel, 0, pat);
    endtask

    function automatic int cyc_runs(input bit [14:0] pat, input int len);
        int r = 0;
        for (int i = 0; i < len; i++)
            if (pat[i] && !pat[(i + len - 1) % len]) r++;
        return r;
    endfunction

    function automatic int len_of(input bit [1:0] sel);
        return (sel == 2'd0) ? 12 : (sel == 2'd1) ? 14 : (sel == 2'd2) ? 15 : 25;
    endfunction

    task automatic measure_ratio(input bit [1:0] sel, input bit [14:0] pat, input string req);
        int len;
        int exp_r;
        int rises;
        bit prev;
        len   = len_of(sel);
        exp_r = (sel == 2'd3) ? 20 * 4 : 20 * cyc_runs(pat, len);
        program_pattern(sel, pat, 1'b1);
        repeat (2 * len) @(negedge clk);
        prev  = div_clk;
        rises = 0;
        for (int i = 0; i < 20 * len; i++) begin
            @(negedge clk);
            if (!prev && div_clk) rises++;
            prev = div_clk;
        end
        check(rises == exp_r, req, rises, exp_r);
    endtask

    task automatic test_reset();
        int highs = 0;
        rst = 1'b1;
        ctl = '0;
        repeat (3) @(negedge clk);
        check(div_clk == 1'b0, "R2 output low in reset", div_clk, 0);
        program_pattern(2'd0, 15'h0fc0, 1'b1);
        repeat (30) @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (div_clk) highs++;
        end
        check(highs == 0, "R2 output low while reset held", highs, 0);
        rst = 1'b0;
        highs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (div_clk) highs++;
        end
        check(highs == 0, "R2 ring cleared by reset", highs, 0);
    endtask

    task automatic test_ratios();
        measure_ratio(2'd0, 15'h0aaa, "R1 R5 div2");
        measure_ratio(2'd0, 15'h0db6, "R5 div3");
        measure_ratio(2'd0, 15'h0ccc, "R5 div4");
        measure_ratio(2'd0, 15'h0e38, "R5 div6");
        measure_ratio(2'd0, 15'h0fc0, "R5 div12");
        measure_ratio(2'd1, 15'h36cc, "R5 div3.5");
        measure_ratio(2'd1, 15'h3c78, "R5 div7");
        measure_ratio(2'd1, 15'h3f80, "R5 div14");
        measure_ratio(2'd2, 15'h6666, "R5 div3.75");
        measure_ratio(2'd2, 15'h739c, "R5 div5");
        measure_ratio(2'd2, 15'h78f0, "R5 div7.5");
        measure_ratio(2'd2, 15'h7f80, "R5 div15");
        measure_ratio(2'd2, 15'h5294, "R5 div2.5");
        measure_ratio(2'd0, 15'h7aaa, "R4 upper ring bits ignored at L=12");
        measure_ratio(2'd1, 15'h4db6, "R4 14-bit loop");
    endtask

    task automatic test_fixed();
        measure_ratio(2'd3, 15'h0000, "R6 div6.25");
        measure_ratio(2'd3, 15'h7fff, "R6 pattern ignored in fixed mode");
    endtask

    task automatic test_preset();
        int highs = 0;
        int early = 0;
        program_pattern(2'd0, 15'h0fc0, 1'b1);
        repeat (30) @(negedge clk);
        write_ctl(1, 0, 2'd0, 1, 15'h0fff);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (div_clk) highs++;
        end
        check(highs == 20, "R3 no rotation while strobe high", highs, 20);
        write_ctl(1, 0, 2'd0, 1, 15'h0800);
        write_ctl(1, 0, 2'd0, 0, 15'h0800);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            if (div_clk) early++;
        end
        check(early == 0, "R3 marker absent before loop completes", early, 0);
        @(negedge clk);
        check(div_clk == 1'b1, "R3 marker back after 12 cycles", div_clk, 1);
    endtask

    task automatic test_enable();
        int highs = 0;
        int run   = 0;
        int tries = 0;
        program_pattern(2'd0, 15'h0fc0, 1'b0);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (div_clk) highs++;
        end
        check(highs == 0, "R8 disabled output low", highs, 0);
        repeat (3) @(negedge clk);
        ctl[19] = 1'b1;
        while (!div_clk && tries < 40) begin
            @(negedge clk);
            tries++;
        end
        while (div_clk && run < 40) begin
            run++;
            @(negedge clk);
        end
        check(run == 6, "R9 first pulse full width", run, 6);
        tries = 0;
        while (!div_clk && tries < 40) begin
            @(negedge clk);
            tries++;
        end
        repeat (2) @(negedge clk);
        ctl[19] = 1'b0;
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (div_clk) highs++;
        end
        check(highs == 3, "R8 disable waits for end of high phase", highs, 3);
    endtask

    task automatic test_bypass();
        int bad = 0;
        write_ctl(1, 1, 2'd0, 0, 15'h7fff);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2;
            if (div_clk !== 1'b1) bad++;
            @(negedge clk); #2;
            if (div_clk !== 1'b0) bad++;
        end
        check(bad == 0, "R7 bypass follows input clock", bad, 0);
        write_ctl(0, 1, 2'd0, 0, 15'h7fff);
        repeat (2) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2;
            if (div_clk !== 1'b0) bad++;
        end
        check(bad == 0, "R7 bypass low when disabled", bad, 0);
    endtask

    initial begin
        n_chk  = 0;
        n_fail = 0;
        done   = 0;
        test_reset();
        test_ratios();
        test_fixed();
        test_preset();
        test_enable();
        test_bypass();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule